// File: doc/BRIEF.md
# Horizontal Sync Jitter Regenerator

This block sits behind a digital video link receiver and produces a horizontal sync output that does not wander against the pixel data. Some sources move the horizontal sync pulse by one pixel clock, early or late, from one line to the next. The data-enable signal keeps a fixed relation to the pixels on every line, so the block uses the falling edge of data-enable as its time base. On each line it measures where the incoming sync rises and how long it lasts, counted from that edge. It rounds the start to the nearest multiple of eight clocks and replays the pulse from those held values on the following line.

The vertical sync travels through the same two-register latency, so the two syncs keep their relative phase. Until the block has seen one complete line, bounded by two data-enable falling edges and containing a whole sync pulse, it passes the incoming horizontal sync through with the same delay. A clean, stable source therefore also comes out correctly timed, and the block can stay in the path for every source.

Top module: `hsync_regen`

## Requirements
- R1: While reset is asserted, and for the two clocks after it is released while the inputs are inactive, both sync outputs sit at their inactive level.
- R2: `vs_out` equals `vs_in` as sampled two clock edges earlier.
- R3: Until lock, `hs_out` equals `hs_in` as sampled two clock edges earlier.
- R4: Position 0 of a line is the first sample with `de_in` low after a sample with it high. Lock is taken at the second such edge after reset, provided the line between the two edges held a sync pulse whose rise and fall were both sampled. From that edge on, `hs_out` is regenerated.
- R5: The measured offset is the position of the first active sample of the incoming sync. It is rounded to the nearest multiple of 8, and a remainder of exactly 4 rounds up.
- R6: After lock, the sync pulse for the sample at position p is active exactly when held_offset <= p < held_offset + held_width. It appears on `hs_out` two clock edges after that sample. The held values used are the ones latched at the data-enable edge that opened the line, including at position 0.
- R7: The candidate width is the larger of the active-sample counts of the incoming pulse on the line just closed and on the line before it that had a pulse.
- R8: At a data-enable falling edge, the held offset and width are both replaced by the candidates only when not yet locked, or when either candidate differs from its held value by more than 1. At any other time, and when both candidates are within 1, the held values do not change.
- R9: A line without a complete incoming sync pulse leaves the held values unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| de_in | input | 1 | Data enable, high during active pixels |
| hs_in | input | 1 | Incoming horizontal sync, polarity set by ACTIVE_HIGH |
| vs_in | input | 1 | Incoming vertical sync, polarity set by ACTIVE_HIGH |
| hs_out | output | 1 | Regenerated horizontal sync |
| vs_out | output | 1 | Vertical sync delayed to match hs_out |

## Verification
Two things can happen in the same cycle. At a data-enable falling edge the held offset and width are replaced, and that same sample is position 0 of the new line, where the output window may already need to open. The sweep drives nominal offsets from 0 up, with ±1 jitter, so offsets of 0 to 3 round to 0. In those cases the pulse starts on the edge itself, and in some lines the incoming sync rises in that very sample. Every output sample is compared against a per-line model built from the requirements. The model holds, rounds, takes the two-line maximum and applies the replacement rule. A pulse that starts one cycle late or uses the stale values shows up as a miscompare.

// File: rtl/hsync_regen.sv
module hsync_regen #(
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter int CW          = 12,
  parameter int GRID_LOG2   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic de_in,
  input  logic hs_in,
  input  logic vs_in,
  output logic hs_out,
  output logic vs_out
);
  localparam logic          INACT = ~ACTIVE_HIGH;
  localparam logic [CW:0]   HALF  = (CW+1)'(1) << (GRID_LOG2 - 1);
  localparam logic [CW:0]   MASK  = ~(((CW+1)'(1) << GRID_LOG2) - (CW+1)'(1));
  localparam logic [CW-1:0] CMAX  = {CW{1'b1}};
  localparam logic [CW-1:0] GMAX  = CMAX & MASK[CW-1:0];

  logic de_r, hs_r, vs_r, vs_o, hs_o;
  logic [CW-1:0] cnt, wcnt, pos_r;
  logic [CW-1:0] meas_off, meas_w, prev_w;
  logic [CW-1:0] off_h, w_h;
  logic got_off, got_w, started, locked;
  logic [1:0] warm;

  wire hs_a    = ACTIVE_HIGH ? hs_in : ~hs_in;
  wire de_fall = de_r & ~de_in;
  wire hs_rise = hs_a & ~hs_r;
  wire hs_fall = ~hs_a & hs_r;
  wire [CW-1:0] pos_now = de_fall ? '0 : cnt;

  wire [CW:0]   rnd      = {1'b0, meas_off} + HALF;
  wire [CW-1:0] cand_off = rnd[CW] ? GMAX : (rnd[CW-1:0] & MASK[CW-1:0]);
  wire [CW-1:0] cand_w   = (meas_w > prev_w) ? meas_w : prev_w;

  function automatic logic far(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW-1:0] d;
    d = (a > b) ? a - b : b - a;
    return d > 1;
  endfunction

  wire update = de_fall && started && got_off && got_w &&
                (!locked || far(cand_off, off_h) || far(cand_w, w_h));

  wire in_win = ({1'b0, pos_r} >= {1'b0, off_h}) &&
                ({1'b0, pos_r} < ({1'b0, off_h} + {1'b0, w_h}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_r <= 1'b0;
      hs_r <= 1'b0;
      vs_r <= INACT;
      vs_o <= INACT;
      hs_o <= 1'b0;
      warm <= '0;
    end else begin
      de_r <= de_in;
      hs_r <= hs_a;
      vs_r <= vs_in;
      vs_o <= vs_r;
      hs_o <= locked ? in_win : hs_r;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      wcnt  <= '0;
      pos_r <= '0;
    end else begin
      pos_r <= pos_now;
      if (de_fall)          cnt <= CW'(1);
      else if (cnt != CMAX) cnt <= cnt + CW'(1);
      if (hs_rise)                   wcnt <= CW'(1);
      else if (hs_a && wcnt != CMAX) wcnt <= wcnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_off <= '0;
      meas_w   <= '0;
      got_off  <= 1'b0;
      got_w    <= 1'b0;
    end else if (de_fall) begin
      got_off <= hs_rise;
      if (hs_rise) meas_off <= '0;
      got_w   <= 1'b0;
    end else begin
      if (hs_rise) begin
        got_off  <= 1'b1;
        meas_off <= cnt;
      end
      if (hs_fall && got_off) begin
        got_w  <= 1'b1;
        meas_w <= wcnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      locked  <= 1'b0;
      prev_w  <= '0;
      off_h   <= '0;
      w_h     <= '0;
    end else if (de_fall) begin
      started <= 1'b1;
      if (got_w) prev_w <= meas_w;
      if (update) begin
        off_h  <= cand_off;
        w_h    <= cand_w;
        locked <= 1'b1;
      end
    end
  end

  assign hs_out = ACTIVE_HIGH ? hs_o : ~hs_o;
  assign vs_out = vs_o;

  a_r2_vs_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (vs_out == $past(vs_in, 2)));
  a_r4_lock_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(de_fall));
  a_r5_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (off_h[GRID_LOG2-1:0] == '0));
  a_r7_width_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (w_h != '0));
  a_r8_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !de_fall |=> ($stable(off_h) && $stable(w_h) && $stable(locked)));
endmodule

// File: tb/hsync_regen_bench.sv
module hsync_regen_bench;
  localparam int A = 8;
  localparam int B = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic hs_out, vs_out;

  hsync_regen u_hsync_regen (.clk(clk), .rst_n(rst_n), .de_in(de_in), .hs_in(hs_in),
                             .vs_in(vs_in), .hs_out(hs_out), .vs_out(vs_out));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic e_hs1 = 0, e_hs2 = 0, e_vs1 = 0, e_vs2 = 0;
  string t1 = "R1", t2 = "R1";
  bit done = 0;

  int valid = 0, hoff = 0, hw = 0, prevw = 0, started = 0;
  int lhas = 0, loff = 0, lw = 0;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic de, input logic hs, input logic ehs, input string tag);
    logic vs;
    @(negedge clk);
    check(hs_out, e_hs2, t2);
    check(vs_out, e_vs2, "R2");
    vs = ((cyc % 37) < 5);
    e_hs2 = e_hs1; e_vs2 = e_vs1; t2 = t1;
    e_hs1 = ehs;   e_vs1 = vs;    t1 = tag;
    de_in = de; hs_in = hs; vs_in = vs;
    cyc++;
  endtask

  task automatic line(input int off, input int w, input int has, input string tag);
    int co, cw;
    for (int i = 0; i < A; i++) step(1'b1, 1'b0, 1'b0, tag);
    if (started != 0 && lhas != 0) begin
      co = ((loff + 4) / 8) * 8;                 // R5 rounding, remainder 4 goes up
      cw = (lw > prevw) ? lw : prevw;            // R7 two-line maximum
      if (valid == 0 || (co > hoff ? co - hoff : hoff - co) > 1 ||
          (cw > hw ? cw - hw : hw - cw) > 1) begin   // R8 replacement rule
        valid = 1; hoff = co; hw = cw;
      end
    end                                          // R9: no pulse, nothing replaced
    if (lhas != 0) prevw = lw;
    started = 1;
    for (int p = 0; p < B; p++) begin
      logic h, e;
      h = (has != 0) && p >= off && p < off + w;
      e = (valid != 0) ? (p >= hoff && p < hoff + hw) : h;   // R3 / R4 / R6
      step(1'b0, h, e, (valid != 0) ? tag : "R3");
    end
    lhas = has; loff = off; lw = w;
  endtask

  initial begin
    // R1: inactive outputs while in reset with active inputs
    de_in = 1'b0; hs_in = 1'b1; vs_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(hs_out, 1'b0, "R1");
      check(vs_out, 1'b0, "R1");
    end
    hs_in = 1'b0; vs_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    t1 = "R1"; t2 = "R1";
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, "R1");
    line(5, 4, 1, "R3");
    line(5, 4, 1, "R4");
    line(6, 4, 1, "R4");
    // R5/R6: sweep nominal offsets with jitter, offsets 0..3 open at position 0
    for (int n = 0; n < 32; n++) begin
      for (int j = 0; j < 3; j++) begin
        int o;
        o = n + ((j == 1) ? -1 : (j == 2) ? 1 : 0);
        if (o < 0) o = 0;
        line(o, 2 + (n % 7), 1, "R5");
      end
    end
    // R7: width jitter on trailing edge
    line(20, 6, 1, "R7"); line(20, 7, 1, "R7"); line(20, 6, 1, "R7");
    line(20, 5, 1, "R7"); line(20, 8, 1, "R7"); line(20, 6, 1, "R7");
    line(20, 3, 1, "R7"); line(20, 3, 1, "R7");
    // R8: small jitter held, real mode change tracked
    line(19, 3, 1, "R8"); line(21, 4, 1, "R8"); line(36, 4, 1, "R8");
    line(35, 4, 1, "R8"); line(9, 4, 1, "R8"); line(9, 4, 1, "R8");
    // R9: lines without a pulse
    line(0, 0, 0, "R9"); line(0, 0, 0, "R9"); line(30, 10, 1, "R9");
    line(30, 10, 1, "R9");
    // R6: pulse rising on the data-enable edge itself
    line(0, 5, 1, "R6"); line(1, 5, 1, "R6"); line(0, 5, 1, "R6");
    line(2, 12, 1, "R6"); line(3, 12, 1, "R6");
    step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b0, "R6");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule